// File: doc/BRIEF.md
# Resumable Serial Result Readout Port

This block is the device-side output port that hands a 24-bit conversion result to an external host over a serial link. The host supplies the serial clock and an active-low frame select. The block loads a new word from a parallel input and then signals data-ready by pulling an active-low flag low. The host opens a frame by pulling frame select low. The most significant bit appears on the data line before any clock edge. Each following bit is shifted out on a falling edge of the serial clock, and the host samples it on the next rising edge.

The host may close the frame part way through a word and reopen it later, as many times as it likes. The block keeps its place in the word across these breaks. Data-ready stays low until every bit has been taken, and goes high on the final falling edge of the word. The three-state data pin is modelled as a data output plus a separate output-enable.

The serial clock and frame select are brought into the system clock domain through two-flop synchronisers. The host clock must therefore run several times slower than the system clock. A new word that arrives while a read is under way is held back and loaded once that read finishes.

Top module: `sro_readout_port`

## Requirements
- R1: After reset, data-ready (`drdy_n_o`) is high (no word available) and the output enable (`sdo_oe_o`) is low.
- R2: A load strobe (`load_i` high for one clock) with no read in progress latches `word_i` and drives `drdy_n_o` low.
- R3: When frame select goes low with a word available, `sdo_oe_o` goes high and `sdo_o` shows bit 23 (the MSB) before any serial clock edge.
- R4: Each falling edge of the serial clock, taken while the frame is open, advances the output by one bit, from MSB towards LSB. Bit 23-k is shown after the k-th falling edge.
- R5: The 23rd falling edge presents bit 0 while `drdy_n_o` is still low. The 24th falling edge drives `drdy_n_o` high, and `sdo_oe_o` is low whenever `drdy_n_o` is high.
- R6: When frame select goes high in mid-word, `sdo_oe_o` drops within a few system clocks and `drdy_n_o` stays low.
- R7: When frame select goes low again after a break, output resumes at the next unread bit. This holds for any number of breaks in one word.
- R8: A load strobe during a read does not disturb the word being read and does not raise data-ready. The new word is loaded, and `drdy_n_o` driven low, once the current word has been fully read.
- R9: Serial clock falling edges while frame select is high do not advance the bit position.
- R10: Serial clock edges while no word is available have no effect: `sdo_oe_o` stays low, `drdy_n_o` stays high, and the next loaded word starts at its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Host serial clock (asynchronous) |
| frame_n_i | input | 1 | Host read frame select, active low (asynchronous) |
| load_i | input | 1 | One-cycle strobe to load a new result |
| word_i | input | 24 | Parallel result to load |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data pin |
| drdy_n_o | output | 1 | Data-ready flag, active low |

## Verification
A bit counter that slips or sticks shows up straight away as a wrong bit on the host's next rising-edge sample. It also shows up one word-length later, when data-ready rises early or late against the 24th falling edge. A lost position across a frame break shows as a mismatch on the first bit read after the frame reopens. A wrongly handled deferred load shows either as corrupted bits in the word being read, or as data-ready staying high after that word completes. Output-enable errors are visible within a few system clocks of frame select rising, or of data-ready going high.

// File: rtl/sro_pkg.sv
package sro_pkg;
  localparam int SRO_SYNC_STAGES = 2;
  localparam int SRO_WORD_W      = 24;

  function automatic int sro_cnt_w(input int w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/sro_sync.sv
module sro_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sro_fall_det.sv
module sro_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;
endmodule

// File: rtl/sro_load_ctl.sv
module sro_load_ctl #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         busy,
  input  logic         have,
  output logic         take,
  output logic [W-1:0] take_word
);
  logic         pend_q;
  logic [W-1:0] pend_word_q;
  logic         direct;

  assign direct    = load_i & ~busy;
  assign take      = direct | (pend_q & ~have);
  assign take_word = direct ? word_i : pend_word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_word_q <= '0;
    end else if (load_i && busy) begin
      pend_q      <= 1'b1;
      pend_word_q <= word_i;
    end else if (take) begin
      pend_q      <= 1'b0;
    end
  end
endmodule

// File: rtl/sro_shift_core.sv
module sro_shift_core #(
  parameter int W  = 24,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall,
  input  logic          frame_act,
  input  logic          take,
  input  logic [W-1:0]  take_word,
  output logic          sdo,
  output logic          oe,
  output logic          drdy_n,
  output logic          busy,
  output logic          have,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          have_q, have_d;
  logic          oe_q, drdy_n_q;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    have_d = have_q;
    if (take) begin
      sh_d   = take_word;
      cnt_d  = '0;
      have_d = 1'b1;
    end else if (have_q && frame_act && fall) begin
      sh_d = {sh_q[W-2:0], 1'b0};
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        have_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      have_q   <= 1'b0;
      oe_q     <= 1'b0;
      drdy_n_q <= 1'b1;
    end else begin
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      have_q   <= have_d;
      oe_q     <= have_d & frame_act;
      drdy_n_q <= ~have_d;
    end
  end

  assign sdo    = sh_q[W-1];
  assign oe     = oe_q;
  assign drdy_n = drdy_n_q;
  assign have   = have_q;
  assign busy   = have_q & ((cnt_q != '0) | frame_act);
  assign cnt    = cnt_q;
endmodule

// File: rtl/sro_readout_port.sv
module sro_readout_port #(
  parameter int W      = sro_pkg::SRO_WORD_W,
  parameter int STAGES = sro_pkg::SRO_SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_i,
  input  logic         frame_n_i,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic         drdy_n_o
);
  localparam int CW = sro_pkg::sro_cnt_w(W);

  logic          sclk_s, frame_n_s, frame_act, fall;
  logic          take, busy, have;
  logic [W-1:0]  take_word;
  logic [CW-1:0] cnt;

  sro_sync #(.N(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst(rst), .d(sclk_i), .q(sclk_s)
  );

  sro_sync #(.N(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_sync_frame (
    .clk(clk), .rst(rst), .d(frame_n_i), .q(frame_n_s)
  );

  assign frame_act = ~frame_n_s;

  sro_fall_det u_fall (
    .clk(clk), .rst(rst), .lvl(sclk_s), .fall(fall)
  );

  sro_load_ctl #(.W(W)) u_load (
    .clk(clk), .rst(rst), .load_i(load_i), .word_i(word_i),
    .busy(busy), .have(have), .take(take), .take_word(take_word)
  );

  sro_shift_core #(.W(W), .CW(CW)) u_core (
    .clk(clk), .rst(rst), .fall(fall), .frame_act(frame_act),
    .take(take), .take_word(take_word),
    .sdo(sdo_o), .oe(sdo_oe_o), .drdy_n(drdy_n_o),
    .busy(busy), .have(have), .cnt(cnt)
  );
endmodule

// File: rtl/sro_readout_port_chk.sv
module sro_readout_port_chk #(
  parameter int W  = 24,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_act,
  input logic          fall,
  input logic          take,
  input logic [CW-1:0] cnt,
  input logic          sdo_oe_o,
  input logic          drdy_n_o
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  p_oe_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
    sdo_oe_o |-> !drdy_n_o);

  p_oe_off_frame_high_r6: assert property (@(posedge clk) disable iff (rst)
    !frame_act |=> !sdo_oe_o);

  p_ready_rise_last_edge_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(drdy_n_o) |-> ($past(fall) && $past(frame_act) && $past(cnt) == LAST));

  p_pos_hold_no_edge_r9: assert property (@(posedge clk) disable iff (rst)
    (!(fall && frame_act) && !take) |=> $stable(cnt));

  p_take_sets_ready_r2: assert property (@(posedge clk) disable iff (rst)
    take |=> !drdy_n_o);

  p_one_step_r4: assert property (@(posedge clk) disable iff (rst)
    (fall && frame_act && !drdy_n_o && !take && cnt != LAST) |=> (cnt - $past(cnt)) == CW'(1));
endmodule

bind sro_readout_port sro_readout_port_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .frame_act(frame_act), .fall(fall), .take(take),
  .cnt(cnt), .sdo_oe_o(sdo_oe_o), .drdy_n_o(drdy_n_o)
);

// File: tb/sro_readout_port_bench.sv
`timescale 1ns/1ps
module sro_readout_port_bench;
  localparam int H = 12;
  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    {24'hA5C3F0, 24'h000000},
    {24'h123456, 24'h000800},
    {24'hFFFFFF, 24'h924924},
    {24'h800001, 24'h7FFFFE},
    {24'h5A5A5A, 24'h400000},
    {24'h0F0F0F, 24'h010101}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        frame_n = 1'b1;
  logic        load = 1'b0;
  logic [23:0] word = '0;
  logic        sdo, sdo_oe, drdy_n;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  sro_readout_port u_sro_readout_port (
    .clk(clk), .rst(rst), .sclk_i(sclk), .frame_n_i(frame_n),
    .load_i(load), .word_i(word),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .drdy_n_o(drdy_n)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_load(input logic [23:0] w);
    word = w; load = 1'b1;
    wait_clk(1);
    load = 1'b0;
  endtask

  task automatic sclk_cycle();
    sclk = 1'b1; wait_clk(H);
    sclk = 1'b0; wait_clk(H);
  endtask

  task automatic read_word(input logic [23:0] w, input logic [23:0] brk,
                           input int load_at, input logic [23:0] w2);
    logic resumed;
    resumed = 1'b0;
    frame_n = 1'b0; wait_clk(H);
    chk("R3 oe after frame low", sdo_oe, 1);
    for (int i = 23; i >= 0; i--) begin
      chk(resumed ? "R7 R9 resumed bit" : (i == 23 ? "R3 msb first" : "R4 bit order"), sdo, w[i]);
      resumed = 1'b0;
      if (i == 0) chk("R5 ready low before last edge", drdy_n, 0);
      if (i == load_at) begin
        pulse_load(w2); wait_clk(3);
        chk("R8 ready held during read", drdy_n, 0);
        chk("R8 bit kept after load", sdo, w[i]);
      end
      sclk_cycle();
      if (brk[i] && i > 0) begin
        frame_n = 1'b1; wait_clk(H);
        chk("R6 oe off on break", sdo_oe, 0);
        chk("R6 ready low on break", drdy_n, 0);
        sclk_cycle(); sclk_cycle();
        chk("R9 ready low after ignored edges", drdy_n, 0);
        frame_n = 1'b0; wait_clk(H);
        chk("R7 oe back on resume", sdo_oe, 1);
        resumed = 1'b1;
      end
    end
    if (load_at < 0) begin
      chk("R5 ready high after last edge", drdy_n, 1);
      chk("R5 oe off with ready high", sdo_oe, 0);
    end else begin
      chk("R8 deferred word loaded", drdy_n, 0);
    end
    frame_n = 1'b1; wait_clk(H);
  endtask

  initial begin
    wait_clk(4);
    chk("R1 ready high in reset", drdy_n, 1);
    chk("R1 oe low in reset", sdo_oe, 0);
    rst = 1'b0;
    wait_clk(4);
    chk("R1 ready high after reset", drdy_n, 1);
    chk("R1 oe low after reset", sdo_oe, 0);

    for (int v = 0; v < NV; v++) begin
      pulse_load(VEC[v][47:24]); wait_clk(2);
      chk("R2 ready low after load", drdy_n, 0);
      read_word(VEC[v][47:24], VEC[v][23:0], -1, 24'h0);
    end

    // R10: clock edges with no word available
    frame_n = 1'b0; wait_clk(H);
    sclk_cycle(); sclk_cycle(); sclk_cycle();
    chk("R10 oe stays low idle", sdo_oe, 0);
    chk("R10 ready stays high idle", drdy_n, 1);
    frame_n = 1'b1; wait_clk(H);
    pulse_load(24'hC00003); wait_clk(2);
    chk("R2 R10 ready low after load", drdy_n, 0);
    read_word(24'hC00003, 24'h000100, -1, 24'h0);

    // R8: load during a read is deferred
    pulse_load(24'h3C96E1); wait_clk(2);
    read_word(24'h3C96E1, 24'h020000, 18, 24'hB7E15A);
    read_word(24'hB7E15A, 24'h000010, -1, 24'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule